// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block watches one memory request port and keeps the reservations that back load-linked / store-conditional synchronization for several requesting contexts. A context is named by a CPU number together with a thread number. A locked read records that context's reservation: it allocates a table entry, or rewrites the address of the entry it already holds. Every write, plain or conditional, is compared against all stored reservations. Any entry on the written granule is removed, whichever context owns it.

A conditional store succeeds only if its own context still holds a reservation on the same granule when the store arrives. The block answers each conditional store with a pass/fail flag. It also gives the memory array a write enable that is raised for every plain store and for successful conditional stores only. Lookup, match and clear take one cycle per request. The results appear on registered outputs in the following cycle. When every entry is in use, a new reservation takes the entry that was allocated longest ago.

Top module: `llres_monitor`

## Requirements
- R1: Reset empties the table. After reset all outputs are low, and a conditional store issued with no prior locked read fails.
- R2: A locked read (op code 1) from a context with no entry allocates an entry. A conditional store (op code 3) from that context to the same granule then passes with `sc_ok_o`=1 and `mem_we_o`=1.
- R3: A context holds at most one entry. A second locked read from it replaces the stored address: a conditional store to the old address fails, and one to the new address passes. No extra entry is consumed.
- R4: Addresses are reduced to a granule by dropping the low GRAN_BITS bits (default 3, so 8 bytes) before they are stored or compared. Addresses differing only in bits [2:0] match. A difference in bit 3 does not match.
- R5: Plain reads (op code 0) and locked reads never remove any reservation.
- R6: A write removes every entry on the written granule, for all contexts. Entries on other granules are kept.
- R7: A plain store (op code 2) always succeeds. One cycle later `mem_we_o`=1 and `sc_done_o`=0.
- R8: A conditional store raises `sc_done_o` one cycle later. `sc_ok_o` is 1 for success and 0 for failure, and `mem_we_o` equals `sc_ok_o`.
- R9: A conditional store fails when the only reservation on its granule belongs to another context, and it still removes that reservation.
- R10: A new allocation uses the lowest free entry. When all entries are valid, it replaces the entry allocated earliest.
- R11: Outputs are registered, one cycle after the request. A cycle with no request or with a read leaves all three outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_op_i | input | 2 | 0 read, 1 locked read, 2 store, 3 conditional store |
| req_cpu_i | input | CPU_W | CPU number of the requester |
| req_thr_i | input | THR_W | Thread number of the requester |
| req_addr_i | input | ADDR_W | Byte address of the request |
| mem_we_o | output | 1 | Write enable to the memory array, registered |
| sc_done_o | output | 1 | Conditional store result valid, registered |
| sc_ok_o | output | 1 | Conditional store succeeded, registered |

## Verification
A single conditional store both grades itself and clears the reservations of every context on its granule. Both results come from the table state before that cycle. The bench provokes the overlap by giving two contexts reservations on one granule and sending a conditional store from one of them. The first store must pass. A following conditional store from the other context must then fail, which shows that the clear took effect in the same request that was graded. The case of a foreign-only reservation, which must fail and still be cleared, is covered the same way.

// File: rtl/llres_pkg.sv
package llres_pkg;
  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_LREAD  = 2'd1,
    OP_WRITE  = 2'd2,
    OP_CWRITE = 2'd3
  } llres_op_e;
endpackage

// File: rtl/llres_age.sv
// Allocation-order tracker: picks the lowest free entry, else the oldest one.
module llres_age #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch_en,
  input  logic [IW-1:0] touch_idx,
  input  logic [N-1:0]  valid_vec,
  output logic [IW-1:0] victim_idx
);
  localparam logic [N-1:0] ONE_N = 1;

  // older_q[i][j] set: entry i was allocated before entry j
  logic [N-1:0] older_q [N];
  logic [N-1:0] older_d [N];
  logic [N-1:0] oldest_vec;

  always_comb begin
    for (int i = 0; i < N; i++) older_d[i] = older_q[i];
    if (touch_en) begin
      for (int i = 0; i < N; i++) begin
        older_d[touch_idx][i] = 1'b0;
        older_d[i][touch_idx] = (IW'(i) != touch_idx);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) older_q[i] <= '0;
    end else if (touch_en) begin
      for (int i = 0; i < N; i++) older_q[i] <= older_d[i];
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_oldest
    assign oldest_vec[g] = &(older_q[g] | (ONE_N << g));
  end

  always_comb begin
    logic have_free;
    have_free  = 1'b0;
    victim_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        victim_idx = IW'(i);
        have_free  = 1'b1;
      end
    end
    if (!have_free) begin
      for (int i = 0; i < N; i++) begin
        if (oldest_vec[i]) victim_idx = IW'(i);
      end
    end
  end

  // R10
  full_one_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&valid_vec) |-> ($countones(oldest_vec) == 1));
endmodule

// File: rtl/llres_table.sv
// Reservation storage with per-entry context and granule comparators.
module llres_table #(
  parameter int N     = 4,
  parameter int CPU_W = 2,
  parameter int THR_W = 2,
  parameter int TAG_W = 29,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [CPU_W-1:0] wr_cpu,
  input  logic [THR_W-1:0] wr_thr,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [N-1:0]     clr_vec,
  input  logic [CPU_W-1:0] lk_cpu,
  input  logic [THR_W-1:0] lk_thr,
  input  logic [TAG_W-1:0] lk_tag,
  output logic [N-1:0]     valid_vec,
  output logic [N-1:0]     ctx_hit,
  output logic [N-1:0]     tag_hit
);
  for (genvar g = 0; g < N; g++) begin : g_ent
    logic             v_q, v_d, sel;
    logic [CPU_W-1:0] cpu_q;
    logic [THR_W-1:0] thr_q;
    logic [TAG_W-1:0] tag_q;

    assign sel = wr_en && (wr_idx == IW'(g));

    always_comb begin
      v_d = v_q;
      if (clr_vec[g]) v_d = 1'b0;
      if (sel)        v_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= 1'b0;
      else        v_q <= v_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cpu_q <= '0;
        thr_q <= '0;
        tag_q <= '0;
      end else if (sel) begin
        cpu_q <= wr_cpu;
        thr_q <= wr_thr;
        tag_q <= wr_tag;
      end
    end

    assign valid_vec[g] = v_q;
    assign ctx_hit[g]   = v_q && (cpu_q == lk_cpu) && (thr_q == lk_thr);
    assign tag_hit[g]   = v_q && (tag_q == lk_tag);

    // R6
    clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[g] && !sel) |=> !valid_vec[g]);
  end
endmodule

// File: rtl/llres_monitor.sv
// Load-linked reservation monitor top.
module llres_monitor
  import llres_pkg::*;
#(
  parameter int N_ENTRIES = 4,
  parameter int CPU_W     = 2,
  parameter int THR_W     = 2,
  parameter int ADDR_W    = 32,
  parameter int GRAN_BITS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [CPU_W-1:0]  req_cpu_i,
  input  logic [THR_W-1:0]  req_thr_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              mem_we_o,
  output logic              sc_done_o,
  output logic              sc_ok_o
);
  localparam int TAG_W = ADDR_W - GRAN_BITS;
  localparam int IW    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;

  llres_op_e          op;
  logic [TAG_W-1:0]   tag;
  logic               is_lr, is_wr, is_sc;
  logic [N_ENTRIES-1:0] valid_vec, ctx_hit, tag_hit, clr_vec;
  logic               own_hit, sc_pass, wr_allow;
  logic [IW-1:0]      own_idx, victim_idx, tbl_idx;
  logic               mem_we_d, sc_done_d, sc_ok_d;

  assign op    = llres_op_e'(req_op_i);
  assign tag   = req_addr_i[ADDR_W-1:GRAN_BITS];
  assign is_lr = req_valid_i && (op == OP_LREAD);
  assign is_sc = req_valid_i && (op == OP_CWRITE);
  assign is_wr = req_valid_i && ((op == OP_WRITE) || (op == OP_CWRITE));

  always_comb begin
    own_idx = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (ctx_hit[i]) own_idx = IW'(i);
    end
  end

  assign own_hit  = |ctx_hit;
  assign tbl_idx  = own_hit ? own_idx : victim_idx;
  assign clr_vec  = is_wr ? tag_hit : '0;
  assign sc_pass  = |(tag_hit & ctx_hit);
  assign wr_allow = is_wr && (!is_sc || sc_pass);

  llres_table #(
    .N(N_ENTRIES), .CPU_W(CPU_W), .THR_W(THR_W), .TAG_W(TAG_W)
  ) i_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(is_lr), .wr_idx(tbl_idx),
    .wr_cpu(req_cpu_i), .wr_thr(req_thr_i), .wr_tag(tag),
    .clr_vec(clr_vec),
    .lk_cpu(req_cpu_i), .lk_thr(req_thr_i), .lk_tag(tag),
    .valid_vec(valid_vec), .ctx_hit(ctx_hit), .tag_hit(tag_hit)
  );

  llres_age #(.N(N_ENTRIES)) i_age (
    .clk(clk), .rst_n(rst_n),
    .touch_en(is_lr && !own_hit), .touch_idx(victim_idx),
    .valid_vec(valid_vec), .victim_idx(victim_idx)
  );

  always_comb begin
    mem_we_d  = wr_allow;
    sc_done_d = is_sc;
    sc_ok_d   = is_sc && sc_pass;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_we_o  <= 1'b0;
      sc_done_o <= 1'b0;
      sc_ok_o   <= 1'b0;
    end else begin
      mem_we_o  <= mem_we_d;
      sc_done_o <= sc_done_d;
      sc_ok_o   <= sc_ok_d;
    end
  end

  // R3
  one_entry_per_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctx_hit));
  // R7
  plain_store_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_op_i == 2'd2) |=> (mem_we_o && !sc_done_o));
  // R8
  sc_we_follows_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_done_o |-> (mem_we_o == sc_ok_o));
  // R5
  read_keeps_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_op_i == 2'd0) |=> $stable(valid_vec));
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |=> (!mem_we_o && !sc_done_o && !sc_ok_o));
endmodule

// File: tb/test_llres_monitor.sv
module test_llres_monitor;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid_i;
  logic [1:0]  req_op_i;
  logic [1:0]  req_cpu_i;
  logic [1:0]  req_thr_i;
  logic [31:0] req_addr_i;
  logic        mem_we_o, sc_done_o, sc_ok_o;

  always #5 clk = ~clk;

  llres_monitor i_llres_monitor (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid_i), .req_op_i(req_op_i),
    .req_cpu_i(req_cpu_i), .req_thr_i(req_thr_i), .req_addr_i(req_addr_i),
    .mem_we_o(mem_we_o), .sc_done_o(sc_done_o), .sc_ok_o(sc_ok_o)
  );

  typedef struct {
    bit    we;
    bit    done;
    bit    ok;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   failures = 0;
  bit   finished = 0;

  // reference reservation list
  bit          m_v   [N];
  int          m_cpu [N];
  int          m_thr [N];
  logic [28:0] m_tag [N];
  int          m_age [N];
  int          age_ctr = 0;

  task automatic issue(input int op, input int cpu, input int thr,
                       input logic [31:0] addr, input string req);
    exp_t e;
    logic [28:0] t;
    int idx;
    bit pass;
    t = addr[31:3];
    e.we = 0; e.done = 0; e.ok = 0; e.req = req;
    if (op == 1) begin
      idx = -1;
      for (int i = 0; i < N; i++)
        if (m_v[i] && m_cpu[i] == cpu && m_thr[i] == thr) idx = i;
      if (idx >= 0) m_tag[idx] = t;
      else begin
        for (int i = N - 1; i >= 0; i--) if (!m_v[i]) idx = i;
        if (idx < 0) begin
          idx = 0;
          for (int i = 1; i < N; i++) if (m_age[i] < m_age[idx]) idx = i;
        end
        m_v[idx] = 1; m_cpu[idx] = cpu; m_thr[idx] = thr;
        m_tag[idx] = t; m_age[idx] = age_ctr; age_ctr++;
      end
    end else if (op >= 2) begin
      pass = (op == 2);
      for (int i = 0; i < N; i++)
        if (m_v[i] && m_tag[i] == t && m_cpu[i] == cpu && m_thr[i] == thr) pass = 1;
      for (int i = 0; i < N; i++)
        if (m_v[i] && m_tag[i] == t) m_v[i] = 0;
      e.we = pass; e.done = (op == 3); e.ok = (op == 3) && pass;
    end
    @(negedge clk);
    req_valid_i = 1'b1;
    req_op_i    = 2'(op);
    req_cpu_i   = 2'(cpu);
    req_thr_i   = 2'(thr);
    req_addr_i  = addr;
    exp_q.push_back(e);
  endtask

  task automatic idle(input string req);
    exp_t e;
    e.we = 0; e.done = 0; e.ok = 0; e.req = req;
    @(negedge clk);
    req_valid_i = 1'b0;
    exp_q.push_back(e);
  endtask

  // monitor: one expected item per edge, sampled after the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (mem_we_o !== e.we || sc_done_o !== e.done || sc_ok_o !== e.ok) begin
          failures++;
          $display("FAIL %s: we/done/ok actual=%b%b%b expected=%b%b%b",
                   e.req, mem_we_o, sc_done_o, sc_ok_o, e.we, e.done, e.ok);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_age[i] = 0; m_cpu[i] = 0; m_thr[i] = 0; m_tag[i] = '0;
    end
    rst_n = 1'b0;
    req_valid_i = 1'b0; req_op_i = 2'd0; req_cpu_i = 2'd0;
    req_thr_i = 2'd0; req_addr_i = '0;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (mem_we_o !== 1'b0 || sc_done_o !== 1'b0 || sc_ok_o !== 1'b0) begin
      failures++;
      $display("FAIL R1: reset outputs actual=%b%b%b expected=000",
               mem_we_o, sc_done_o, sc_ok_o);
    end
    @(negedge clk);
    rst_n = 1'b1;

    issue(3, 0, 0, 32'h100, "R1");          // no reservation: fails
    issue(1, 0, 0, 32'h100, "R2");
    issue(3, 0, 0, 32'h104, "R4");          // same granule: passes
    issue(1, 0, 0, 32'h108, "R4");
    issue(3, 0, 0, 32'h100, "R4");          // bit 3 differs: fails
    issue(2, 3, 3, 32'h10C, "R7");          // clear leftover 0x108

    issue(1, 1, 0, 32'h200, "R3");
    issue(1, 1, 0, 32'h300, "R3");
    issue(3, 1, 0, 32'h200, "R3");          // old address: fails
    issue(3, 1, 0, 32'h300, "R3");          // new address: passes

    issue(1, 2, 1, 32'h400, "R5");
    issue(0, 1, 1, 32'h400, "R5");
    issue(0, 2, 1, 32'h404, "R5");
    issue(1, 3, 3, 32'h400, "R5");
    issue(3, 2, 1, 32'h400, "R5");          // passes and clears (3,3)
    issue(3, 3, 3, 32'h400, "R6");          // fails

    issue(1, 0, 1, 32'h500, "R6");
    issue(1, 1, 1, 32'h500, "R6");
    issue(1, 2, 2, 32'h600, "R6");
    issue(2, 3, 0, 32'h504, "R7");
    idle("R11");
    issue(3, 0, 1, 32'h500, "R6");
    issue(3, 1, 1, 32'h500, "R6");
    issue(3, 2, 2, 32'h600, "R6");          // other granule kept

    issue(1, 0, 2, 32'h700, "R9");
    issue(3, 1, 2, 32'h700, "R9");          // foreign reservation: fails
    issue(3, 0, 2, 32'h700, "R9");          // cleared by the previous one

    issue(1, 0, 3, 32'h800, "R10");
    issue(1, 1, 3, 32'h810, "R10");
    issue(1, 2, 3, 32'h820, "R10");
    issue(1, 3, 3, 32'h830, "R10");
    issue(1, 3, 2, 32'h840, "R10");         // full: evicts (0,3)
    issue(3, 0, 3, 32'h800, "R10");
    issue(3, 1, 3, 32'h810, "R10");         // frees a slot
    issue(1, 3, 1, 32'h850, "R10");         // takes the free slot
    issue(3, 2, 3, 32'h820, "R10");
    issue(3, 3, 1, 32'h850, "R8");
    issue(0, 0, 0, 32'h900, "R11");
    idle("R11");
    idle("R11");
    @(posedge clk);
    #4;
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule